// File: doc/BRIEF.md
# March C-minus Memory Self-Test Controller

This block runs a fixed six-element March C- test on a synchronous single-port RAM with a one-cycle read latency. A single-cycle start pulse launches a run. The controller then drives the RAM's chip select, write enable, address and write data, and issues one operation on every clock cycle with no idle gaps. It checks every read word against the value the algorithm expects.

When the run ends, the block raises a done flag and a pass flag. It also holds the address of the first read that did not match, together with the bits that differed, so that a downstream repair stage can map a spare over that location. Any mismatch after the first one sets a sticky flag that marks more than one fail. Once a repair has been applied, the same controller is started again, and only a clean second run is reported as good.

The address width and the data width are parameters. The two "any order" elements are swept in ascending order.

Top module: `mbist_march_ctrl`

## Requirements
- R1: A run issues six elements in this order: ascending write 0; ascending (read 0, write 1); ascending (read 1, write 0); descending (read 0, write 1); descending (read 1, write 0); ascending read 0. The value 0 means all DW bits are 0 on ram_wdata_o or in the expected word, and 1 means all DW bits are 1. A write has ram_cs_o=1 and ram_we_o=1. A read has ram_cs_o=1 and ram_we_o=0.
- R2: An ascending element visits addresses 0 to 2^AW-1 in order, and a descending element visits them in reverse. In a two-operation element, the read and the write of one address fall on consecutive cycles, and only then does the address move on.
- R3: Operations are issued back to back, starting on the cycle after the edge that accepts start. done_o is first seen high after 10*2^AW+1 rising edges following that edge. ram_cs_o is high only while busy_o is high.
- R4: The returned word of every read, one cycle after the read is issued, is compared with the expected word. With no mismatch, pass_o=1 at done. With any mismatch, pass_o=0 at done. pass_o is never high while done_o is low.
- R5: fail_addr_o holds the address of the first mismatching read. fail_mask_o holds the XOR of the returned and expected words at that read. Later mismatches leave both unchanged.
- R6: multi_fail_o is set by any mismatch after the first one in a run and stays set until the next accepted start. A run with exactly one mismatch ends with multi_fail_o=0.
- R7: done_o and pass_o hold their values until the next accepted start. A start pulse that arrives while busy_o=1 is ignored and does not change the timing of the run.
- R8: An accepted start clears done_o, fail_addr_o, fail_mask_o and multi_fail_o, so a re-run after repair reports only its own result.
- R9: After reset, busy_o, done_o, pass_o, ram_cs_o and multi_fail_o are 0, and fail_addr_o and fail_mask_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle run request |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable (1 = write) |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_rdata_i | input | DW | RAM read data, valid one cycle after a read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, results valid |
| pass_o | output | 1 | Finished run saw no mismatch |
| fail_addr_o | output | AW | Address of first failing read |
| fail_mask_o | output | DW | Differing bits at first failing read |
| multi_fail_o | output | 1 | More than one mismatch in the run |

## Verification
The first RAM operation appears on the cycle after the accepting edge. After that, one operation is due on each following cycle, and the bench compares the port values at each falling edge against a sequence it builds itself. The verdict and the capture registers are due one edge after the last read's data returns, that is 10*2^AW+1 edges after the accepting edge. The bench counts edges to that point and reads the results only once done_o is seen. Faults on the behavioural RAM are chosen so that the expected first-fail address, the expected mask and the multi-fail flag follow directly from the element order: a stuck bit at 0x089, a coupling fault from 0x088 onto 0x089, and a stuck bit at the top address.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } mb_state_e;

  localparam int unsigned NUM_ELEM = 6;
  localparam int unsigned ELEM_W   = $clog2(NUM_ELEM);

  typedef logic [ELEM_W-1:0] elem_t;

  localparam elem_t ELEM_FIRST = elem_t'(0);
  localparam elem_t ELEM_LAST  = elem_t'(NUM_ELEM - 1);

  // Elements 1..4 carry a read followed by a write.
  function automatic logic elem_two_op(elem_t e);
    return (e != ELEM_FIRST) && (e != ELEM_LAST);
  endfunction

  // Elements 3 and 4 sweep downward.
  function automatic logic elem_down(elem_t e);
    return (e == elem_t'(3)) || (e == elem_t'(4));
  endfunction

  // Write in phase 1 of two-op elements, always in element 0, never in the last.
  function automatic logic op_write(elem_t e, logic ph);
    if (e == ELEM_FIRST) return 1'b1;
    if (e == ELEM_LAST)  return 1'b0;
    return ph;
  endfunction

  // Data bit written, or expected on read, for this element and phase.
  function automatic logic op_value(elem_t e, logic ph);
    if ((e == ELEM_FIRST) || (e == ELEM_LAST)) return 1'b0;
    return ph ? e[0] : ~e[0];
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          ld_hi_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam logic [AW-1:0] ADDR_MAX = '1;
  localparam logic [AW-1:0] ADDR_MIN = '0;
  localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_n;
  logic          addr_en;

  always_comb begin
    addr_en = ld_i | step_i;
    if (ld_i) begin
      addr_n = ld_hi_i ? ADDR_MAX : ADDR_MIN;
    end else if (down_i) begin
      addr_n = addr_q - ADDR_ONE;
    end else begin
      addr_n = addr_q + ADDR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= ADDR_MIN;
    end else if (addr_en) begin
      addr_q <= addr_n;
    end
  end

  assign addr_o = addr_q;
  assign last_o = down_i ? (addr_q == ADDR_MIN) : (addr_q == ADDR_MAX);

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  last_i,
  output logic  issue_o,
  output elem_t elem_o,
  output logic  ph_o,
  output logic  down_o,
  output logic  ld_o,
  output logic  ld_hi_o,
  output logic  step_o,
  output logic  clr_o,
  output logic  busy_o,
  output logic  done_o
);

  mb_state_e state_q, state_n;
  elem_t     elem_q, elem_n;
  logic      ph_q, ph_n;
  elem_t     elem_nx;
  logic      start_ok;
  logic      seq_en;

  assign elem_nx  = elem_q + elem_t'(1);
  assign start_ok = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

  always_comb begin
    state_n = state_q;
    elem_n  = elem_q;
    ph_n    = ph_q;
    issue_o = 1'b0;
    ld_o    = 1'b0;
    ld_hi_o = 1'b0;
    step_o  = 1'b0;
    clr_o   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_ok) begin
          state_n = ST_RUN;
          elem_n  = ELEM_FIRST;
          ph_n    = 1'b0;
          ld_o    = 1'b1;
          clr_o   = 1'b1;
        end
      end
      ST_RUN: begin
        issue_o = 1'b1;
        if (elem_two_op(elem_q) && !ph_q) begin
          ph_n = 1'b1;
        end else begin
          ph_n = 1'b0;
          if (last_i) begin
            if (elem_q == ELEM_LAST) begin
              state_n = ST_FLUSH;
            end else begin
              elem_n  = elem_nx;
              ld_o    = 1'b1;
              ld_hi_o = elem_down(elem_nx);
            end
          end else begin
            step_o = 1'b1;
          end
        end
      end
      ST_FLUSH: begin
        state_n = ST_DONE;
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  assign seq_en = (state_n != state_q) || (elem_n != elem_q) || (ph_n != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= ELEM_FIRST;
      ph_q    <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_n;
      elem_q  <= elem_n;
      ph_q    <= ph_n;
    end
  end

  assign elem_o = elem_q;
  assign ph_o   = ph_q;
  assign down_o = elem_down(elem_q);
  assign busy_o = (state_q == ST_RUN) || (state_q == ST_FLUSH);
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/mbist_data_gen.sv
module mbist_data_gen
  import mbist_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  elem_t         elem_i,
  input  logic          ph_i,
  output logic          we_o,
  output logic [DW-1:0] word_o
);

  logic bit_val;

  assign bit_val = op_value(elem_i, ph_i);
  assign we_o    = op_write(elem_i, ph_i);
  assign word_o  = {DW{bit_val}};

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_mask_o,
  output logic          multi_o
);

  logic          rd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] diff;
  logic          mism;
  logic          cap_en;
  logic          fail_q, multi_q;
  logic [AW-1:0] faddr_q;
  logic [DW-1:0] fmask_q;

  // Align the expectation with the RAM's one-cycle read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      exp_q  <= '0;
    end else if (rd_i) begin
      addr_q <= addr_i;
      exp_q  <= exp_i;
    end
  end

  assign diff   = rdata_i ^ exp_q;
  assign mism   = rd_q && (diff != '0);
  assign cap_en = clr_i || (mism && !fail_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (clr_i) begin
      fail_q <= 1'b0;
    end else if (mism) begin
      fail_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      multi_q <= 1'b0;
    end else if (clr_i) begin
      multi_q <= 1'b0;
    end else if (mism && fail_q) begin
      multi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
      fmask_q <= '0;
    end else if (cap_en) begin
      faddr_q <= clr_i ? '0 : addr_q;
      fmask_q <= clr_i ? '0 : diff;
    end
  end

  assign fail_o      = fail_q;
  assign multi_o     = multi_q;
  assign fail_addr_o = faddr_q;
  assign fail_mask_o = fmask_q;

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
  import mbist_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          ram_cs_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [DW-1:0] fail_mask_o,
  output logic          multi_fail_o
);

  logic          rst_s1, rst_sn;
  logic          issue, down, ld, ld_hi, step, clr, last, ph, we, fail;
  logic          done;
  elem_t         elem;
  logic [AW-1:0] addr;
  logic [DW-1:0] word;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  mbist_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_sn),
    .start_i (start_i),
    .last_i  (last),
    .issue_o (issue),
    .elem_o  (elem),
    .ph_o    (ph),
    .down_o  (down),
    .ld_o    (ld),
    .ld_hi_o (ld_hi),
    .step_o  (step),
    .clr_o   (clr),
    .busy_o  (busy_o),
    .done_o  (done)
  );

  mbist_addr_gen #(.AW(AW)) agen_i (
    .clk     (clk),
    .rst_n   (rst_sn),
    .ld_i    (ld),
    .ld_hi_i (ld_hi),
    .step_i  (step),
    .down_i  (down),
    .addr_o  (addr),
    .last_o  (last)
  );

  mbist_data_gen #(.DW(DW)) dgen_i (
    .elem_i (elem),
    .ph_i   (ph),
    .we_o   (we),
    .word_o (word)
  );

  mbist_cmp #(.AW(AW), .DW(DW)) cmp_i (
    .clk         (clk),
    .rst_n       (rst_sn),
    .clr_i       (clr),
    .rd_i        (issue && !we),
    .addr_i      (addr),
    .exp_i       (word),
    .rdata_i     (ram_rdata_i),
    .fail_o      (fail),
    .fail_addr_o (fail_addr_o),
    .fail_mask_o (fail_mask_o),
    .multi_o     (multi_fail_o)
  );

  assign ram_cs_o    = issue;
  assign ram_we_o    = issue && we;
  assign ram_addr_o  = addr;
  assign ram_wdata_o = word;
  assign done_o      = done;
  assign pass_o      = done && !fail;

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          ram_cs_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [AW-1:0] fail_addr_o,
  input logic [DW-1:0] fail_mask_o,
  input logic          multi_fail_o
);

  // R3
  ram_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_o |-> busy_o);

  // R4
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

  // R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_fail_o && !start_i) |=> ($stable(fail_addr_o) && $stable(fail_mask_o)));

  // R6
  multi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_fail_o && !start_i) |=> multi_fail_o);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(pass_o)));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs_o && start_i) |=> busy_o);

endmodule

bind mbist_march_ctrl mbist_march_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ram_cs_o     (ram_cs_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pass_o       (pass_o),
  .fail_addr_o  (fail_addr_o),
  .fail_mask_o  (fail_mask_o),
  .multi_fail_o (multi_fail_o)
);

// File: tb/mbist_march_ctrl_tb_top.sv
module mbist_march_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          ram_cs_o, ram_we_o;
  logic [AW-1:0] ram_addr_o;
  logic [DW-1:0] ram_wdata_o;
  logic [DW-1:0] ram_rdata_i;
  logic          busy_o, done_o, pass_o, multi_fail_o;
  logic [AW-1:0] fail_addr_o;
  logic [DW-1:0] fail_mask_o;

  int checks = 0;
  int errors = 0;

  // Behavioural RAM fault controls
  logic          stk_en;
  logic [AW-1:0] stk_addr;
  logic [DW-1:0] stk_mask;
  logic          cpl_en;
  logic [AW-1:0] agg_addr, vic_addr;
  logic [DW-1:0] vic_mask;
  logic [DW-1:0] mem [NW];

  mbist_march_ctrl #(.AW(AW), .DW(DW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ram_cs_o     (ram_cs_o),
    .ram_we_o     (ram_we_o),
    .ram_addr_o   (ram_addr_o),
    .ram_wdata_o  (ram_wdata_o),
    .ram_rdata_i  (ram_rdata_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .fail_addr_o  (fail_addr_o),
    .fail_mask_o  (fail_mask_o),
    .multi_fail_o (multi_fail_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (ram_cs_o) begin
      if (ram_we_o) begin
        if (cpl_en && ram_addr_o == agg_addr && mem[agg_addr][0] === 1'b0 && ram_wdata_o[0])
          mem[vic_addr] <= mem[vic_addr] | vic_mask;
        mem[ram_addr_o] <= ram_wdata_o;
      end else begin
        ram_rdata_i <= (stk_en && ram_addr_o == stk_addr) ?
                       (mem[ram_addr_o] & ~stk_mask) : mem[ram_addr_o];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Runs one complete test, comparing each RAM operation with the expected March stream.
  task automatic do_run(input int busy_pulse_at, output int cyc);
    int bad = 0;
    int first_bad = -1;
    int idx = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    cyc = 0;
    for (int e = 0; e < 6; e++) begin
      int nops = (e == 0 || e == 5) ? 1 : 2;
      for (int i = 0; i < NW; i++) begin
        int a = (e == 3 || e == 4) ? (NW - 1 - i) : i;
        for (int p = 0; p < nops; p++) begin
          logic xwe;
          logic xval;
          xwe  = (e == 0) ? 1'b1 : (e == 5) ? 1'b0 : (p == 1);
          xval = (nops == 1) ? 1'b0 :
                 (p == 0) ? (e == 2 || e == 4) : (e == 1 || e == 3);
          if (ram_cs_o !== 1'b1 || ram_we_o !== xwe || ram_addr_o !== AW'(a) ||
              (xwe && ram_wdata_o !== {DW{xval}})) begin
            bad++;
            if (first_bad < 0) first_bad = idx;
          end
          idx++;
          @(negedge clk);
          cyc++;
          if (cyc == busy_pulse_at) start_i = 1'b1;
          else start_i = 1'b0;
        end
      end
    end
    start_i = 1'b0;
    while (done_o !== 1'b1 && cyc < 3 * 10 * NW) begin
      @(negedge clk);
      cyc++;
    end
    // R1 R2: op order, direction, data, read-then-write pairing
    chk("R1/R2", "mismatching ops (first index)", bad, 0);
    if (bad != 0) $display("  first mismatching op index %0d", first_bad);
    // R3
    chk("R3", "edges to done", cyc, 10 * NW + 1);
  endtask

  task automatic clear_faults();
    stk_en = 1'b0;
    cpl_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9", "busy", busy_o, 0);
    chk("R9", "done", done_o, 0);
    chk("R9", "pass", pass_o, 0);
    chk("R9", "ram_cs", ram_cs_o, 0);
    chk("R9", "multi", multi_fail_o, 0);
    chk("R9", "fail_addr", fail_addr_o, 0);
    chk("R9", "fail_mask", fail_mask_o, 0);
  endtask

  task automatic t_clean();
    int c;
    clear_faults();
    do_run(-1, c);
    chk("R4", "pass clean", pass_o, 1);
    chk("R6", "multi clean", multi_fail_o, 0);
    chk("R3", "busy at done", busy_o, 0);
  endtask

  task automatic t_hold();
    logic p;
    p = pass_o;
    repeat (25) @(negedge clk);
    chk("R7", "done held", done_o, 1);
    chk("R7", "pass held", pass_o, p);
  endtask

  task automatic t_stuck();
    int c;
    clear_faults();
    stk_en = 1'b1; stk_addr = AW'('h089); stk_mask = 8'h08;
    do_run(-1, c);
    chk("R4", "pass stuck", pass_o, 0);
    chk("R5", "fail_addr stuck", fail_addr_o, 'h089);
    chk("R5", "fail_mask stuck", fail_mask_o, 'h08);
    chk("R6", "multi stuck", multi_fail_o, 1);
  endtask

  task automatic t_busy_start();
    int c;
    do_run(100, c);
    chk("R7", "fail_addr after ignored start", fail_addr_o, 'h089);
    chk("R7", "done after ignored start", done_o, 1);
  endtask

  task automatic t_repair();
    int c;
    clear_faults();
    do_run(-1, c);
    chk("R8", "pass after repair", pass_o, 1);
    chk("R8", "fail_addr cleared", fail_addr_o, 0);
    chk("R8", "fail_mask cleared", fail_mask_o, 0);
    chk("R8", "multi cleared", multi_fail_o, 0);
  endtask

  task automatic t_coupling();
    int c;
    clear_faults();
    cpl_en = 1'b1; agg_addr = AW'('h088); vic_addr = AW'('h089); vic_mask = 8'h01;
    do_run(-1, c);
    chk("R4", "pass coupling", pass_o, 0);
    chk("R5", "fail_addr coupling", fail_addr_o, 'h089);
    chk("R5", "fail_mask coupling", fail_mask_o, 'h01);
    chk("R6", "single fail multi", multi_fail_o, 0);
  endtask

  task automatic t_first_of_two();
    int c;
    clear_faults();
    cpl_en = 1'b1; agg_addr = AW'('h088); vic_addr = AW'('h089); vic_mask = 8'h01;
    stk_en = 1'b1; stk_addr = AW'(NW - 1); stk_mask = 8'h80;
    do_run(-1, c);
    chk("R5", "first of two addr", fail_addr_o, 'h089);
    chk("R5", "first of two mask", fail_mask_o, 'h01);
    chk("R6", "multi two faults", multi_fail_o, 1);
  endtask

  task automatic t_top_addr();
    int c;
    clear_faults();
    stk_en = 1'b1; stk_addr = AW'(NW - 1); stk_mask = 8'h80;
    do_run(-1, c);
    chk("R5", "top addr", fail_addr_o, NW - 1);
    chk("R5", "top mask", fail_mask_o, 'h80);
    chk("R4", "pass top", pass_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start_i = 1'b0;
    stk_en = 1'b0; stk_addr = '0; stk_mask = '0;
    cpl_en = 1'b0; agg_addr = '0; vic_addr = '0; vic_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean();
    t_hold();
    t_stuck();
    t_busy_start();
    t_repair();
    t_coupling();
    t_first_of_two();
    t_top_addr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule